// File: doc/BRIEF.md
# Four-Cell Boundary Scan Register Chain

This block is a short boundary-scan register. Each of its cells sits on one pin of a small circuit under test. A cell can sample the value on its pin, pass a bit serially to the next cell, and hold a value in a second register that can drive the pin in place of its normal source. A test access controller outside the block supplies the shift, capture and update controls, all on the test clock. The block itself has no state machine.

The cells form a chain. Serial data enters cell 0 and leaves from the last cell, so the first bit shifted in arrives in the last cell. Every update register loads on one shared strobe, so all driven pins change in the same cycle. The mode select chooses what reaches each pin. In normal mode the pin's own input passes straight through. In test mode the update register drives the pin. The cell design is the same whether it is used for an input or an output. An asynchronous active-low reset clears all storage and puts the pins back in normal mode.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_n` is low, every capture register and every update register is 0. Right after reset is released, `scan_out` is 0, and with `mode_sel`=1 `pout` is 0.
- R2: When `capture_en`=1 and `shift_en`=0 at a rising `tck` edge, each cell's capture register loads `pin[i]`.
- R3: When `capture_en`=1 and `shift_en`=1 at a rising edge, the capture registers move one place toward the serial output. Cell 0 takes `scan_in`, and cell i takes cell i-1's old value.
- R4: `scan_out` always equals the capture register of cell NUM_CELLS-1. After NUM_CELLS shifts, bit k of the shifted-in sequence (k=0 first) sits in cell NUM_CELLS-1-k.
- R5: When `capture_en`=0, the capture registers keep their value whatever `shift_en`, `scan_in` and `pin` do.
- R6: When `update_en`=1 at a rising edge, every update register loads its own cell's capture register value from before that edge, all in the same cycle.
- R7: When `update_en`=0, the update registers keep their value.
- R8: When `mode_sel`=0, `pout[i]` equals `pin[i]` combinationally.
- R9: When `mode_sel`=1 and reset is not active, `pout[i]` equals cell i's update register, whatever `pin` is.
- R10: While `rst_n` is low, `pout` equals `pin` even when `mode_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial data into cell 0 |
| shift_en | input | 1 | 1: capture registers shift; 0: they sample `pin` |
| capture_en | input | 1 | Clock enable for the capture registers |
| update_en | input | 1 | Clock enable for all update registers |
| mode_sel | input | 1 | 0: normal pass-through; 1: update registers drive `pout` |
| pin | input | NUM_CELLS | Parallel input, bit i to cell i |
| pout | output | NUM_CELLS | Parallel output, bit i from cell i |
| scan_out | output | 1 | Serial data from the last cell |

## Verification
The update registers can only be seen through `pout` in test mode. The capture registers can only be seen one bit at a time on `scan_out`. Proving that a held or shifted value is correct therefore takes a full round trip. The stimulus does this for every pair of a captured pattern and a shifted-in pattern: capture, then update, then shift out while shifting in, then update again, and finally read each result back on `pout`. Hold behaviour is checked the same way. Disabled cycles with disturbing inputs come before an update, and a later readback shows that nothing moved. Reset is also asserted mid-run over loaded cells.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  // Source for the capture register: serial neighbour or parallel pin.
  function automatic logic cap_next(input logic shift, input logic serial_bit,
                                    input logic par_bit);
    return shift ? serial_bit : par_bit;
  endfunction

  // Pin driver: the update register in test mode, otherwise pass-through.
  function automatic logic pin_drive(input logic test_mode, input logic held_bit,
                                     input logic par_bit);
    return test_mode ? held_bit : par_bit;
  endfunction

endpackage

// File: rtl/bscan_cap_stage.sv
`timescale 1ns/1ps
module bscan_cap_stage
  import bscan_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic serial_in,
  input  logic par_in,
  output logic q
);
  logic d;
  assign d = cap_next(shift_en, serial_in, par_in);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/bscan_upd_stage.sv
`timescale 1ns/1ps
module bscan_upd_stage (
  input  logic tck,
  input  logic rst_n,
  input  logic upd_en,
  input  logic d,
  output logic q
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (upd_en) q <= d;
  end
endmodule

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell
  import bscan_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic upd_en,
  input  logic shift_en,
  input  logic test_mode,
  input  logic serial_in,
  input  logic par_in,
  output logic cap_q,
  output logic upd_q,
  output logic par_out
);
  bscan_cap_stage u_cap (
    .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
    .serial_in(serial_in), .par_in(par_in), .q(cap_q)
  );

  bscan_upd_stage u_upd (
    .tck(tck), .rst_n(rst_n), .upd_en(upd_en), .d(cap_q), .q(upd_q)
  );

  assign par_out = pin_drive(test_mode, upd_q, par_in);
endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain #(
  parameter int NUM_CELLS = 4
) (
  input  logic                 tck,
  input  logic                 rst_n,
  input  logic                 scan_in,
  input  logic                 shift_en,
  input  logic                 capture_en,
  input  logic                 update_en,
  input  logic                 mode_sel,
  input  logic [NUM_CELLS-1:0] pin,
  output logic [NUM_CELLS-1:0] pout,
  output logic                 scan_out
);
  localparam int LAST = NUM_CELLS - 1;

  // Internal state exposed as named wires for the checker.
  logic [NUM_CELLS-1:0] cap_q;
  logic [NUM_CELLS-1:0] upd_q;
  logic [NUM_CELLS-1:0] serial_src;
  logic                 test_mode;

  // Reset forces the pins back to normal mode.
  assign test_mode = mode_sel & rst_n;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign serial_src[i] = scan_in;
    end else begin : g_link
      assign serial_src[i] = cap_q[i-1];
    end

    bscan_cell u_cell (
      .tck(tck), .rst_n(rst_n), .cap_en(capture_en), .upd_en(update_en),
      .shift_en(shift_en), .test_mode(test_mode), .serial_in(serial_src[i]),
      .par_in(pin[i]), .cap_q(cap_q[i]), .upd_q(upd_q[i]), .par_out(pout[i])
    );
  end

  assign scan_out = cap_q[LAST];
endmodule

// File: rtl/bscan_chain_chk.sv
`timescale 1ns/1ps
module bscan_chain_chk #(
  parameter int N = 4
) (
  input logic         tck,
  input logic         rst_n,
  input logic         scan_in,
  input logic         shift_en,
  input logic         capture_en,
  input logic         update_en,
  input logic         mode_sel,
  input logic [N-1:0] pin,
  input logic [N-1:0] pout,
  input logic         scan_out,
  input logic [N-1:0] cap_q,
  input logic [N-1:0] upd_q
);
  assert_reset_clear_R1: assert property (@(posedge tck)
    !rst_n |-> (cap_q == '0 && upd_q == '0));

  assert_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && !shift_en) |=> cap_q == $past(pin));

  assert_shift_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && shift_en) |=> cap_q == {$past(cap_q[N-2:0]), $past(scan_in)});

  assert_scan_out_R4: assert property (@(posedge tck) disable iff (!rst_n)
    scan_out == cap_q[N-1]);

  assert_cap_hold_R5: assert property (@(posedge tck) disable iff (!rst_n)
    !capture_en |=> $stable(cap_q));

  assert_update_R6: assert property (@(posedge tck) disable iff (!rst_n)
    update_en |=> upd_q == $past(cap_q));

  assert_upd_hold_R7: assert property (@(posedge tck) disable iff (!rst_n)
    !update_en |=> $stable(upd_q));

  assert_normal_R8: assert property (@(posedge tck) disable iff (!rst_n)
    !mode_sel |-> pout == pin);

  assert_test_mode_R9: assert property (@(posedge tck) disable iff (!rst_n)
    mode_sel |-> pout == upd_q);

  assert_reset_normal_R10: assert property (@(posedge tck)
    !rst_n |-> pout == pin);
endmodule

bind bscan_chain bscan_chain_chk #(.N(NUM_CELLS)) u_chk (
  .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
  .capture_en(capture_en), .update_en(update_en), .mode_sel(mode_sel),
  .pin(pin), .pout(pout), .scan_out(scan_out), .cap_q(cap_q), .upd_q(upd_q)
);

// File: tb/tb_bscan_chain.sv
`timescale 1ns/1ps
module tb_bscan_chain;
  localparam int N = 4;

  logic         tck = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_in = 1'b0;
  logic         shift_en = 1'b0;
  logic         capture_en = 1'b0;
  logic         update_en = 1'b0;
  logic         mode_sel = 1'b0;
  logic [N-1:0] pin = '0;
  logic [N-1:0] pout;
  logic         scan_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 tck = ~tck;

  bscan_chain #(.NUM_CELLS(N)) dut (
    .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .mode_sel(mode_sel),
    .pin(pin), .pout(pout), .scan_out(scan_out)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive controls after a falling edge, take one rising edge, return at the next falling edge.
  task automatic cyc(input logic cap, input logic shf, input logic upd, input logic sin);
    capture_en = cap; shift_en = shf; update_en = upd; scan_in = sin;
    @(posedge tck);
    @(negedge tck);
    capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
  endtask

  initial begin
    logic [N-1:0] last_upd;
    // R10 and R1: pass-through during reset even in test mode
    mode_sel = 1; pin = 4'b1011;
    repeat (2) @(negedge tck);
    chk("R10 reset pass-through", pout, 4'b1011);
    rst_n = 1;
    @(negedge tck);
    chk("R1 update regs clear after reset", pout, 4'b0000);
    chk("R1 scan_out clear after reset", {3'b0, scan_out}, 4'b0000);
    last_upd = '0;

    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        mode_sel = 1;
        pin = p[N-1:0];
        cyc(1, 0, 0, 0);
        chk("R7 update regs hold without strobe", pout, last_upd);
        cyc(0, 0, 1, 0);
        chk("R2/R6 captured pattern on pins", pout, p[N-1:0]);
        pin = ~p[N-1:0];
        #1 chk("R9 test mode ignores pin", pout, p[N-1:0]);
        mode_sel = 0;
        #1 chk("R8 normal mode passes pin", pout, ~p[N-1:0]);
        mode_sel = 1;
        // R5: disabled capture with disturbing inputs
        pin = q[N-1:0];
        cyc(0, 1, 0, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 0);
        chk("R5 capture regs hold when disabled", pout, p[N-1:0]);
        // R3/R4: shift p out while shifting q in (first bit = q[3])
        for (int k = 0; k < N; k++) begin
          chk("R4 scan_out bit order", {3'b0, scan_out}, {3'b0, p[N-1-k]});
          cyc(1, 1, 0, q[N-1-k]);
        end
        cyc(0, 0, 1, 0);
        chk("R3 shifted pattern lands in cells", pout, q[N-1:0]);
        last_upd = q[N-1:0];
        if (q == 15) begin
          pin = 4'b0110;
          #1 rst_n = 0;
          #1 chk("R10 mid-run reset pass-through", pout, 4'b0110);
          chk("R1 mid-run reset clears scan_out", {3'b0, scan_out}, 4'b0000);
          @(negedge tck);
          rst_n = 1;
          #1 chk("R1 update regs cleared by reset", pout, 4'b0000);
          last_upd = '0;
          @(negedge tck);
        end
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (R1..): actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule